// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns the transmit nibble stream of a 100 Mb/s copper port into a three-level line symbol stream. It runs entirely on a 125 MHz clock. A strobe, high for one clock in every five, marks the 25 MHz nibble boundary. On each strobe the block chooses one 5-bit code group. That group is the 4B/5B code of the nibble, a start or end delimiter, or idle. The five bits then leave one per clock. Each bit is XORed with an 11-bit scrambler key, passed through NRZI and finally through MLT-3.

A frame starts when transmit enable is seen high on a strobe. The two nibble slots that follow are given up to the start delimiter pair. While enable stays high, data nibbles are encoded. The first strobe with enable low emits the first end delimiter, and the next strobe emits the second one regardless of enable. Idle fills every other slot.

Top module: `fe_tx_line_coder`

## Requirements
- R1: In a data slot (frame open, `tx_en` high at the strobe) the nibble maps to its 4B/5B code: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R2: The strobe on which `tx_en` is first seen high emits 11000, and the following strobe emits 10001 whatever `tx_en` and `txd` are. The nibbles presented on those two strobes are discarded.
- R3: The first strobe of an open frame with `tx_en` low emits 01101, and the next strobe emits 00111.
- R4: All strobes outside a frame emit the idle group 11111.
- R5: The scrambler is an 11-bit LFSR loaded with `SEED` (default all ones) in reset. It advances every clock: key = s[10]^s[8], then s ← {s[9:0], key}. The line bit is the code bit XOR key.
- R6: A group chosen at a strobe edge leaves MSB first, one bit on each of the five following clock edges. When no group is pending, code bits are 0.
- R7: `nrzi_out` toggles on the clock edge that consumes a scrambled 1 and holds on a 0.
- R8: `mlt_out` (signed, 01 = +1, 11 = −1) steps through 0, +1, 0, −1 on each NRZI toggle and holds otherwise. It never takes the value 10.
- R9: During reset, `nrzi_out` is 0 and `mlt_out` is 0.
- R10: `tx_en` high on the strobe that emits the second end delimiter does not start a frame there; a new frame starts only at a later strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_stb | input | 1 | Nibble boundary strobe, one clock in five |
| tx_en | input | 1 | Transmit enable, sampled at the strobe |
| txd | input | 4 | Transmit nibble, sampled at the strobe |
| nrzi_out | output | 1 | NRZI-coded scrambled bit stream |
| mlt_out | output | 2 | Signed MLT-3 line level |

## Verification
The hardest case to reach is a frame edge that lands on a slot the encoder has already claimed. Examples are enable dropping during the second start delimiter, or enable rising again on the second end delimiter. A port-level bench only sees scrambled, doubly differential levels. The driver therefore keeps its own slot model and queues the expected code group for each strobe. The stimulus includes a one-nibble frame, a frame whose enable lasts a single strobe, and back-to-back frames with enable reasserted on the slot right after it falls. The monitor rebuilds the scrambler, NRZI and MLT-3 on every clock, so any slot decision that differs shows up as a level mismatch.

// File: rtl/fe_tx_line_coder.sv
module fe_tx_line_coder #(
  parameter logic [10:0] SEED = 11'h7FF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nib_stb,
  input  logic       tx_en,
  input  logic [3:0] txd,
  output logic       nrzi_out,
  output logic [1:0] mlt_out
);
  localparam logic [4:0] G_J = 5'b11000, G_K = 5'b10001;
  localparam logic [4:0] G_T = 5'b01101, G_R = 5'b00111, G_I = 5'b11111;

  typedef enum logic [1:0] {S_IDLE, S_K, S_DATA, S_R} slot_t;

  slot_t       st, st_n;
  logic [4:0]  sh, grp;
  logic [10:0] lfsr;
  logic [1:0]  phase;
  logic        key, line;

  function automatic logic [4:0] code5(input logic [3:0] n);
    case (n)
      4'h0: code5 = 5'b11110; 4'h1: code5 = 5'b01001;
      4'h2: code5 = 5'b10100; 4'h3: code5 = 5'b10101;
      4'h4: code5 = 5'b01010; 4'h5: code5 = 5'b01011;
      4'h6: code5 = 5'b01110; 4'h7: code5 = 5'b01111;
      4'h8: code5 = 5'b10010; 4'h9: code5 = 5'b10011;
      4'hA: code5 = 5'b10110; 4'hB: code5 = 5'b10111;
      4'hC: code5 = 5'b11010; 4'hD: code5 = 5'b11011;
      4'hE: code5 = 5'b11100; default: code5 = 5'b11101;
    endcase
  endfunction

  always_comb begin
    grp  = G_I;
    st_n = st;
    case (st)
      S_IDLE: if (tx_en) begin grp = G_J; st_n = S_K; end
      S_K:    begin grp = G_K; st_n = S_DATA; end
      S_DATA: if (tx_en) grp = code5(txd);
              else begin grp = G_T; st_n = S_R; end
      default: begin grp = G_R; st_n = S_IDLE; end
    endcase
  end

  assign key  = lfsr[10] ^ lfsr[8];
  assign line = sh[4] ^ key;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sh    <= '0;
      lfsr  <= SEED;
      nrzi_out <= 1'b0;
      phase <= '0;
    end else begin
      lfsr     <= {lfsr[9:0], key};
      nrzi_out <= nrzi_out ^ line;
      if (line) phase <= phase + 2'd1;
      if (nib_stb) begin
        sh <= grp;
        st <= st_n;
      end else begin
        sh <= {sh[3:0], 1'b0};
      end
    end
  end

  assign mlt_out = phase[0] ? (phase[1] ? 2'b11 : 2'b01) : 2'b00;
endmodule

module fe_tx_line_coder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        nib_stb,
  input logic        tx_en,
  input logic [1:0]  st,
  input logic [4:0]  sh,
  input logic [10:0] lfsr,
  input logic        nrzi_out,
  input logic [1:0]  mlt_out
);
  p_mlt_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mlt_out != 2'b10);
  p_mlt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mlt_out) |-> ($past(mlt_out) == 2'b00 || mlt_out == 2'b00));
  p_toggle_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nrzi_out) |-> !$stable(mlt_out));
  p_hold_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(nrzi_out) |-> $stable(mlt_out));
  p_lfsr_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 11'd0);
  p_start_j_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_stb && tx_en && st == 2'd0) |=> sh == 5'b11000);
  p_idle_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_stb && !tx_en && st == 2'd0) |=> sh == 5'b11111);
  p_end_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_stb && st == 2'd3) |=> (sh == 5'b00111 && st == 2'd0));
endmodule

bind fe_tx_line_coder fe_tx_line_coder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nib_stb(nib_stb), .tx_en(tx_en),
  .st(st), .sh(sh), .lfsr(lfsr), .nrzi_out(nrzi_out), .mlt_out(mlt_out)
);

// File: tb/tb_fe_tx_line_coder.sv
module tb_fe_tx_line_coder;
  logic clk = 0, rst_n = 0, nib_stb = 0, tx_en = 0;
  logic [3:0] txd = 0;
  logic nrzi_out;
  logic [1:0] mlt_out;
  int checks = 0, fails = 0;
  bit finished = 0;

  fe_tx_line_coder dut (.clk(clk), .rst_n(rst_n), .nib_stb(nib_stb), .tx_en(tx_en),
                        .txd(txd), .nrzi_out(nrzi_out), .mlt_out(mlt_out));

  always #4 clk = ~clk;

  logic [4:0] gq[$];
  string      tq[$];
  int         slot = 0;

  function automatic logic [4:0] enc(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic period(input logic en, input logic [3:0] d);
    @(negedge clk);
    nib_stb = 1; tx_en = en; txd = d;
    case (slot)
      0: if (en) begin gq.push_back(5'b11000); tq.push_back("R2"); slot = 1; end
         else begin gq.push_back(5'b11111); tq.push_back("R4"); end
      1: begin gq.push_back(5'b10001); tq.push_back("R2"); slot = 2; end
      2: if (en) begin gq.push_back(enc(d)); tq.push_back("R1"); end
         else begin gq.push_back(5'b01101); tq.push_back("R3"); slot = 3; end
      default: begin gq.push_back(5'b00111); tq.push_back(en ? "R10" : "R3"); slot = 0; end
    endcase
    @(negedge clk) nib_stb = 0;
    repeat (3) @(negedge clk);
  endtask

  logic stb_e = 0, rst_e = 0;
  always @(posedge clk) begin stb_e <= nib_stb; rst_e <= rst_n; end

  logic [10:0] m_lfsr = 11'h7FF;
  logic        m_nrzi = 0;
  logic [1:0]  m_ph = 0;
  logic [4:0]  cur = 0;
  string       ctag = "R6";
  int          idx = 5;

  initial forever begin
    @(negedge clk);
    if (rst_e) begin
      logic cb, k, ln;
      logic [1:0] em;
      cb = (idx < 5) ? cur[4-idx] : 1'b0;
      k  = m_lfsr[10] ^ m_lfsr[8];
      ln = cb ^ k;
      m_lfsr = {m_lfsr[9:0], k};
      m_nrzi = m_nrzi ^ ln;
      if (ln) m_ph = m_ph + 2'd1;
      em = m_ph[0] ? (m_ph[1] ? 2'b11 : 2'b01) : 2'b00;
      checks++;
      if (nrzi_out !== m_nrzi) begin
        fails++;
        $display("FAIL R7 R5 R6 %s: nrzi_out got %0b expected %0b", ctag, nrzi_out, m_nrzi);
      end
      checks++;
      if (mlt_out !== em) begin
        fails++;
        $display("FAIL R8 %s: mlt_out got %b expected %b", ctag, mlt_out, em);
      end
      if (idx < 5) idx++;
      if (stb_e) begin
        if (gq.size() == 0) begin
          fails++;
          $display("FAIL R6: strobe with no expected group, got none expected one");
        end else begin
          cur = gq.pop_front(); ctag = tq.pop_front(); idx = 0;
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      tx_en = ~tx_en; nib_stb = ~nib_stb;
      checks++;
      if (nrzi_out !== 1'b0 || mlt_out !== 2'b00) begin
        fails++;
        $display("FAIL R9: reset outputs got %b/%b expected 0/00", nrzi_out, mlt_out);
      end
    end
    @(negedge clk);
    tx_en = 0; nib_stb = 0; rst_n = 1;
    repeat (4) period(0, 4'h0);
    period(1, 4'h5); period(1, 4'h5);
    for (int i = 0; i < 16; i++) period(1, i[3:0]);
    period(0, 4'h0); period(0, 4'h0); period(0, 4'h0);
    period(1, 4'hA); period(1, 4'hA); period(1, 4'h3); period(0, 4'h0); period(0, 4'h0);
    period(1, 4'h0); period(0, 4'h9); period(0, 4'h0); period(0, 4'h0); period(0, 4'h0);
    period(1, 4'h1); period(1, 4'h1); period(1, 4'hC);
    period(0, 4'h0); period(1, 4'h7); period(1, 4'h7); period(1, 4'h7);
    period(1, 4'hE); period(0, 4'h0); period(0, 4'h0);
    repeat (3) period(0, 4'h0);
    repeat (12) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end
endmodule